// File: doc/BRIEF.md
# Bidirectional Latch/Register Bus Transceiver

This block links an A port and a B port, 18 bits wide, passing data without inversion in both directions. Each direction has its own storage element. That element can be transparent, can hold a value, or can capture on a falling edge of that direction's strobe clock. Each direction also has its own output enable. The A-to-B enable is active high; the B-to-A enable is active low.

The strobe clocks, latch enables and data are sampled by a fast system clock. A strobe falling edge is the first system-clock edge at which the strobe is low after being high. Each port shows its high-impedance state as a per-bit enable vector next to its data vector, so a wrapper at the pad level can build real tri-state pins. An asynchronous active-low reset clears both storage elements to zero.

Top module: `bidir_xcvr`

## Requirements
- R1: While reset is low, both storage elements are zero. With its latch enable low and its output enabled, each port's data output shows zero.
- R2: While the A-to-B latch enable is high and that output is enabled, the B data output equals the A data input in the same cycle.
- R3: With the A-to-B latch enable low and no falling strobe edge, the stored value does not change, whatever the A input does.
- R4: With the A-to-B latch enable low, a strobe falling edge stores the A input present at that system-clock edge. The B output shows it from then on.
- R5: A rising edge of the A-to-B strobe stores nothing.
- R6: After the A-to-B latch enable goes low, the stored value is the last A input it passed at a system-clock edge.
- R7: The A-to-B output enable is active high. When it is low, all 18 bits of the B enable vector are 0 and the B data output is all zeros. When it is high, all 18 enable bits are 1.
- R8: The B-to-A output enable is active low. When it is high, the A enable vector and the A data output are all zeros. When it is low, all 18 enable bits are 1.
- R9: The B-to-A path behaves as R2 to R6 describe, using its own latch enable and strobe, and is independent of the A-to-B controls.
- R10: A strobe falling edge while the latch enable is high has no effect beyond transparency: the output keeps following the input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System sampling clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| a_i | input | 18 | A port data in |
| a_o | output | 18 | A port data out (B-to-A path) |
| a_oe_o | output | 18 | A port per-bit drive enable |
| b_i | input | 18 | B port data in |
| b_o | output | 18 | B port data out (A-to-B path) |
| b_oe_o | output | 18 | B port per-bit drive enable |
| le_ab_i | input | 1 | A-to-B latch enable, high = transparent |
| cp_ab_i | input | 1 | A-to-B strobe, captures on falling edge |
| oe_ab_i | input | 1 | A-to-B output enable, active high |
| le_ba_i | input | 1 | B-to-A latch enable, high = transparent |
| cp_ba_i | input | 1 | B-to-A strobe, captures on falling edge |
| oe_ba_ni | input | 1 | B-to-A output enable, active low |

## Verification
Directed sequences drive one path at a time through each mode:
- transparency;
- hold under a steady strobe while the data churns;
- capture on a strobe fall, where new data arrives together with the edge;
- a rising strobe, which must store nothing;
- the latch enable closing;
- a strobe fall while transparent.

Each of these separates a correct storage rule from a near miss, such as capture on the wrong edge or hold leaking through. Random vectors then toggle both strobes, both latch enables and both output enables together. A reference model in the bench predicts both ports, which exposes any crosstalk between the directions and any swap of enable polarity.

// File: rtl/bxcvr_pkg.sv
package bxcvr_pkg;
  parameter int unsigned DATA_W = 18;
  parameter int unsigned N_DIR  = 2;

  typedef enum logic [1:0] {
    LANE_HOLD    = 2'd0,
    LANE_PASS    = 2'd1,
    LANE_CAPTURE = 2'd2
  } lane_mode_e;
endpackage

// File: rtl/strobe_fall.sv
module strobe_fall (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cp_i,
  output logic fall_o
);
  logic cp_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cp_q <= 1'b0;
    else         cp_q <= cp_i;
  end

  assign fall_o = cp_q & ~cp_i;

  // a fall needs the strobe high again before the next one
  assert_single_fall_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fall_o |=> !fall_o);
endmodule

// File: rtl/lane_store.sv
module lane_store
  import bxcvr_pkg::*;
#(
  parameter int unsigned W = DATA_W
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  input  logic         le_i,
  input  logic         fall_i,
  output logic [W-1:0] y_o
);
  lane_mode_e   mode;
  logic [W-1:0] q;

  always_comb begin
    if (le_i)        mode = LANE_PASS;
    else if (fall_i) mode = LANE_CAPTURE;
    else             mode = LANE_HOLD;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               q <= '0;
    else if (mode != LANE_HOLD) q <= d_i;
  end

  assign y_o = (mode == LANE_PASS) ? d_i : q;

  assert_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!le_i && !fall_i) |=> $stable(q));
  assert_capture_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!le_i && fall_i) |=> (q == $past(d_i)));
  assert_retain_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    le_i |=> (q == $past(d_i)));
endmodule

// File: rtl/port_drive.sv
module port_drive #(
  parameter int unsigned W          = 18,
  parameter bit          ACTIVE_LOW = 1'b0
) (
  input  logic         en_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] d_o,
  output logic [W-1:0] oe_o
);
  logic en_act;

  if (ACTIVE_LOW) begin : g_low
    assign en_act = ~en_i;
  end else begin : g_high
    assign en_act = en_i;
  end

  assign oe_o = {W{en_act}};
  assign d_o  = en_act ? d_i : '0;
endmodule

// File: rtl/bidir_xcvr.sv
module bidir_xcvr
  import bxcvr_pkg::*;
#(
  parameter int unsigned W = DATA_W
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] a_i,
  output logic [W-1:0] a_o,
  output logic [W-1:0] a_oe_o,
  input  logic [W-1:0] b_i,
  output logic [W-1:0] b_o,
  output logic [W-1:0] b_oe_o,
  input  logic         le_ab_i,
  input  logic         cp_ab_i,
  input  logic         oe_ab_i,
  input  logic         le_ba_i,
  input  logic         cp_ba_i,
  input  logic         oe_ba_ni
);
  localparam int unsigned DIR_AB = 0;
  localparam int unsigned DIR_BA = 1;

  logic [N_DIR-1:0][W-1:0] src, lane_y, drv_d, drv_oe;
  logic [N_DIR-1:0]        le, cp, en, fall;

  assign src[DIR_AB] = a_i;
  assign src[DIR_BA] = b_i;
  assign le          = {le_ba_i, le_ab_i};
  assign cp          = {cp_ba_i, cp_ab_i};
  assign en          = {oe_ba_ni, oe_ab_i};

  for (genvar d = 0; d < N_DIR; d++) begin : g_dir
    strobe_fall u_fall (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .cp_i  (cp[d]),
      .fall_o(fall[d])
    );

    lane_store #(.W(W)) u_lane (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .d_i   (src[d]),
      .le_i  (le[d]),
      .fall_i(fall[d]),
      .y_o   (lane_y[d])
    );

    port_drive #(.W(W), .ACTIVE_LOW(d == DIR_BA)) u_drv (
      .en_i(en[d]),
      .d_i (lane_y[d]),
      .d_o (drv_d[d]),
      .oe_o(drv_oe[d])
    );
  end

  assign b_o    = drv_d[DIR_AB];
  assign b_oe_o = drv_oe[DIR_AB];
  assign a_o    = drv_d[DIR_BA];
  assign a_oe_o = drv_oe[DIR_BA];

  assert_ab_pass_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (le_ab_i && oe_ab_i) |-> (b_o == a_i));
  assert_ba_pass_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (le_ba_i && !oe_ba_ni) |-> (a_o == b_i));
  assert_b_off_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !oe_ab_i |-> (b_oe_o == '0 && b_o == '0));
  assert_a_off_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    oe_ba_ni |-> (a_oe_o == '0 && a_o == '0));
  assert_a_on_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !oe_ba_ni |-> (a_oe_o == '1));
endmodule

// File: tb/bidir_xcvr_tb.sv
module bidir_xcvr_tb;
  localparam int W = 18;

  logic         clk = 1'b0;
  logic         rst_n;
  logic [W-1:0] a_in, b_in, a_out, a_oe, b_out, b_oe;
  logic         le_ab, cp_ab, oe_ab, le_ba, cp_ba, oe_ba_n;

  int n_chk  = 0;
  int n_fail = 0;

  // model state
  logic [W-1:0] mq_ab, mq_ba;
  logic         mp_ab, mp_ba;

  always #4 clk = ~clk;

  bidir_xcvr #(.W(W)) u_dut (
    .clk_i(clk), .rst_ni(rst_n),
    .a_i(a_in), .a_o(a_out), .a_oe_o(a_oe),
    .b_i(b_in), .b_o(b_out), .b_oe_o(b_oe),
    .le_ab_i(le_ab), .cp_ab_i(cp_ab), .oe_ab_i(oe_ab),
    .le_ba_i(le_ba), .cp_ba_i(cp_ba), .oe_ba_ni(oe_ba_n)
  );

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mq_ab <= '0; mq_ba <= '0; mp_ab <= 1'b0; mp_ba <= 1'b0;
    end else begin
      if (le_ab || (mp_ab && !cp_ab)) mq_ab <= a_in;
      if (le_ba || (mp_ba && !cp_ba)) mq_ba <= b_in;
      mp_ab <= cp_ab;
      mp_ba <= cp_ba;
    end
  end

  function automatic logic [W-1:0] exp_b();
    return oe_ab ? (le_ab ? a_in : mq_ab) : '0;
  endfunction

  function automatic logic [W-1:0] exp_a();
    return !oe_ba_n ? (le_ba ? b_in : mq_ba) : '0;
  endfunction

  task automatic cmp(string tag, string what, logic [W-1:0] act, logic [W-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  // inputs set just after a falling edge; check, then cross one rising edge
  task automatic step(string tag);
    #1;
    cmp(tag, "b_o",    b_out, exp_b());
    cmp(tag, "b_oe_o", b_oe,  {W{oe_ab}});
    cmp(tag, "a_o",    a_out, exp_a());
    cmp(tag, "a_oe_o", a_oe,  {W{!oe_ba_n}});
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    #(8 * 200000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [W-1:0] held;
    void'($urandom(32'h1d5eed));
    rst_n = 1'b0;
    a_in = 18'h2a5a5; b_in = 18'h15a5a;
    le_ab = 0; cp_ab = 0; oe_ab = 1; le_ba = 0; cp_ba = 0; oe_ba_n = 0;
    @(negedge clk);
    // R1: storage cleared under reset
    step("R1");
    cmp("R1", "b_o literal", b_out, '0);
    rst_n = 1'b1;
    step("R1");

    // R2 transparent
    le_ab = 1; a_in = 18'h12345; step("R2");
    cmp("R2", "b_o literal", b_out, 18'h12345);
    a_in = 18'h3ffff; step("R2");
    // R6 close latch, keep last passed value
    le_ab = 0; step("R6");
    a_in = 18'h00001; step("R6");
    cmp("R6", "b_o literal", b_out, 18'h3ffff);
    // R3 hold with data churn and steady strobe
    for (int i = 0; i < 4; i++) begin a_in = W'($urandom); step("R3"); end
    cmp("R3", "b_o literal", b_out, 18'h3ffff);
    // R5 rising strobe stores nothing
    a_in = 18'h0abcd; cp_ab = 1; step("R5");
    a_in = 18'h0beef; step("R5");
    cmp("R5", "b_o literal", b_out, 18'h3ffff);
    // R4 fall captures data present at that edge
    cp_ab = 0; a_in = 18'h2c0de; step("R4");
    a_in = 18'h11111; step("R4");
    cmp("R4", "b_o literal", b_out, 18'h2c0de);
    // R10 fall while transparent
    le_ab = 1; cp_ab = 1; a_in = 18'h05555; step("R10");
    cp_ab = 0; a_in = 18'h0aaaa; step("R10");
    a_in = 18'h33333; step("R10");
    cmp("R10", "b_o literal", b_out, 18'h33333);
    le_ab = 0;
    // R7 disable B side
    oe_ab = 0; step("R7");
    cmp("R7", "b_oe_o literal", b_oe, '0);
    oe_ab = 1;
    // R9 B-to-A path, A-to-B controls idle
    le_ba = 1; b_in = 18'h1f0f0; step("R9");
    le_ba = 0; held = b_in; b_in = 18'h00f0f; step("R9");
    cp_ba = 1; step("R9");
    cp_ba = 0; b_in = 18'h2222f; step("R9");
    b_in = 18'h0; step("R9");
    cmp("R9", "a_o literal", a_out, 18'h2222f);
    // R8 disable A side
    oe_ba_n = 1; step("R8");
    cmp("R8", "a_oe_o literal", a_oe, '0);
    oe_ba_n = 0; step("R8");
    cmp("R8", "a_oe_o on", a_oe, '1);

    // random mix, both directions at once (R9 independence)
    for (int i = 0; i < 600; i++) begin
      a_in = W'($urandom); b_in = W'($urandom);
      if ($urandom_range(2) == 0) cp_ab = ~cp_ab;
      if ($urandom_range(2) == 0) cp_ba = ~cp_ba;
      le_ab   = ($urandom_range(3) == 0);
      le_ba   = ($urandom_range(3) == 0);
      oe_ab   = ($urandom_range(3) != 0);
      oe_ba_n = ($urandom_range(3) == 0);
      step("R9");
    end
    finish_run();
  end
endmodule